// File: doc/BRIEF.md
# CPU Memory Access Sequencer

This block arbitrates a single 32-bit memory bus between instruction fetch and the data accesses of a small in-order CPU core. While no data access is in progress it places the core's program counter on the address bus. When the core presents a load or store, the block takes the bus, stalls the core through a pause output, and runs a fixed-length access. The length depends on the top address bit. The low half of the address space is treated as clocked memory and gets a short sequence. The upper half gets a longer sequence in which the write strobe stays low on the first and last cycles, so the address is held around the strobe.

For stores, narrow data is copied across the byte lanes, and byte enables are produced in big-endian lane order. For loads, the word on the read bus is captured at the end of the final cycle and handed back with a one-cycle valid pulse. The bus then goes back to fetching from the program counter. A new request is accepted in that same cycle.

Top module: `mem_seq`

## Requirements
- R1: A synchronous active-high reset, including one raised during an access, returns the block to fetch in the following cycle. In that state mem_we, mem_be, pause, mem_wdrive and rdata_valid are all low and mem_addr equals pc.
- R2: While idle, mem_addr follows pc, the write bus is released (mem_wdrive low, mem_wdata zero), and mem_we and mem_be are low. This also holds in the cycle in which a request is first presented.
- R3: A request presented while idle raises pause in the same cycle. Pause then stays high on every access cycle except the final one.
- R4: When req_addr[31] is 0, the access occupies the 3 cycles after acceptance. mem_addr holds the request address throughout. For a store, mem_we is high on all three cycles.
- R5: When req_addr[31] is 1, the access occupies 5 cycles. For a store, mem_we is low on the first and last of them and high on the middle three.
- R6: req_size encodes 0 as byte, 1 as halfword, and 2 or 3 as word. Lane 3 is bits 31:24 and is addressed by offset 0. The byte enables during the access are:
  - byte at offsets 0, 1, 2, 3: 1000, 0100, 0010, 0001
  - halfword: 1100 when address bit 1 is 0, otherwise 0011
  - word: 1111
- R7: On store cycles mem_wdrive is high and mem_wdata carries the data in one of three forms: the low byte repeated four times, the low halfword repeated twice, or the full word.
- R8: A load follows the same cycle counts with mem_we and mem_wdrive low. mem_rdata as seen in the final cycle appears on rdata in the next cycle, with rdata_valid high for exactly that one cycle.
- R9: In the cycle after the final access cycle, mem_addr equals pc again.
- R10: A request presented in the cycle after an access ends is accepted at once, and its timing is the same as for an isolated request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | 32 | Instruction fetch address from the core |
| req_valid | input | 1 | Core requests a data access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Data access address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Read data from memory |
| mem_addr | output | 32 | Memory address bus |
| mem_wdata | output | 32 | Write data bus, zero when released |
| mem_wdrive | output | 1 | Write data bus is being driven |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| pause | output | 1 | Stall request to the core |
| rdata | output | 32 | Captured load data |
| rdata_valid | output | 1 | One-cycle pulse marking rdata |

## Verification
Two things can happen in the same cycle: a finished load delivers its data through rdata_valid, and a newly presented request raises pause. The bench provokes this by holding req_valid across the final edge of a load while swapping in a store to the other address region. In that one cycle it checks that the load word is on rdata and that pause and the fetch address are both present. It then checks that the following store runs its full, unshortened sequence.

// File: rtl/mem_seq.sv
`timescale 1ns/1ps
module mem_seq #(
  parameter int AW        = 32,
  parameter int LO_CYCLES = 3,
  parameter int HI_CYCLES = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pc,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          mem_wdrive,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic          pause,
  output logic [31:0]   rdata,
  output logic          rdata_valid
);

  localparam int CW = $clog2(HI_CYCLES + 1);
  localparam logic [CW-1:0] LO_N = CW'(LO_CYCLES);
  localparam logic [CW-1:0] HI_N = CW'(HI_CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_addr;
  logic [31:0]   a_data;
  logic          a_we, a_hi;
  logic [1:0]    a_size;
  logic          accept, first, last;
  logic [3:0]    lane_be;
  logic [31:0]   lane_data;

  assign accept = !busy && req_valid;
  assign last   = busy && (cnt == ONE);
  assign first  = busy && (cnt == (a_hi ? HI_N : LO_N));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cnt         <= '0;
      rdata_valid <= 1'b0;
      rdata       <= '0;
      a_addr      <= '0;
      a_data      <= '0;
      a_we        <= 1'b0;
      a_hi        <= 1'b0;
      a_size      <= 2'd0;
    end else begin
      rdata_valid <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        cnt    <= req_addr[AW-1] ? HI_N : LO_N;
        a_addr <= req_addr;
        a_data <= req_wdata;
        a_we   <= req_write;
        a_hi   <= req_addr[AW-1];
        a_size <= req_size;
      end else if (busy) begin
        cnt <= cnt - ONE;
        if (last) begin
          busy <= 1'b0;
          if (!a_we) begin
            rdata       <= mem_rdata;
            rdata_valid <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    case (a_size)
      2'd0: begin
        lane_be   = 4'b1000 >> a_addr[1:0];
        lane_data = {4{a_data[7:0]}};
      end
      2'd1: begin
        lane_be   = a_addr[1] ? 4'b0011 : 4'b1100;
        lane_data = {2{a_data[15:0]}};
      end
      default: begin
        lane_be   = 4'b1111;
        lane_data = a_data;
      end
    endcase
  end

  assign pause      = accept || (busy && !last);
  assign mem_addr   = busy ? a_addr : pc;
  assign mem_we     = busy && a_we && !(a_hi && (first || last));
  assign mem_be     = busy ? lane_be : 4'b0000;
  assign mem_wdrive = busy && a_we;
  assign mem_wdata  = mem_wdrive ? lane_data : 32'h0;

  // R3: an accepted request keeps the core stalled into the next cycle
  p_pause_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> pause);

  // R4: address is held for the whole access
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(mem_addr));

  // R5: first cycle of an upper-region access never strobes
  p_hi_setup_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && req_addr[AW-1]) |=> !mem_we);

  // R6: a byte access enables exactly one lane
  p_byte_lane_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && a_size == 2'd0) |-> ($countones(mem_be) == 1));

  // R8: read-data valid is a single-cycle pulse
  p_rvalid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |=> !rdata_valid);

  // R9: fetch address is restored after the final cycle
  p_back_to_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    last |=> (mem_addr == pc));

  logic [CW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !busy) run_q <= '0;
    else              run_q <= run_q + ONE;
    // R4 and R5: total access length matches the address region
    if (!rst && last)
      p_len_r4: assert ((run_q + ONE) == (a_hi ? HI_N : LO_N));
  end

endmodule

// File: tb/mem_seq_tb.sv
`timescale 1ns/1ps
module mem_seq_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata, mem_rdata;
  logic [31:0] mem_addr, mem_wdata, rdata;
  logic        mem_wdrive, mem_we, pause, rdata_valid;
  logic [3:0]  mem_be;

  int checks = 0;
  int errors = 0;
  bit exp_rv = 1'b0;
  logic [31:0] exp_rd = '0;

  always #10 clk = ~clk;

  mem_seq u_dut (
    .clk(clk), .rst(rst), .pc(pc), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdrive(mem_wdrive), .mem_we(mem_we), .mem_be(mem_be), .pause(pause),
    .rdata(rdata), .rdata_valid(rdata_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd0) begin
      case (a[1:0])
        2'd0: return 4'b1000;
        2'd1: return 4'b0100;
        2'd2: return 4'b0010;
        default: return 4'b0001;
      endcase
    end else if (sz == 2'd1) return a[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd0) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (sz == 2'd1) return {d[15:0], d[15:0]};
    return d;
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk({"R9 fetch addr ", tag}, mem_addr, pc);
    chk({"R2 pause idle ", tag}, {31'b0, pause}, 32'd0);
    chk({"R2 we idle ", tag}, {31'b0, mem_we}, 32'd0);
    chk({"R2 be idle ", tag}, {28'b0, mem_be}, 32'd0);
    chk({"R2 wdrive idle ", tag}, {31'b0, mem_wdrive}, 32'd0);
    chk({"R2 wdata released ", tag}, mem_wdata, 32'd0);
    chk({"R8 rdata_valid ", tag}, {31'b0, rdata_valid}, {31'b0, exp_rv});
    if (exp_rv) chk({"R8 rdata ", tag}, rdata, exp_rd);
    exp_rv = 1'b0;
    step();
  endtask

  task automatic access(input logic [31:0] a, input bit w, input logic [1:0] sz,
                        input logic [31:0] d, input logic [31:0] rd, input bit keep,
                        input string tag);
    int n;
    n = a[31] ? 5 : 3;
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a;
    req_wdata = d; mem_rdata = rd;
    @(negedge clk);
    chk({"R3 pause on request ", tag}, {31'b0, pause}, 32'd1);
    chk({"R2 fetch addr in request cycle ", tag}, mem_addr, pc);
    chk({"R2 no strobe in request cycle ", tag}, {31'b0, mem_we}, 32'd0);
    chk({"R10 rdata_valid in request cycle ", tag}, {31'b0, rdata_valid}, {31'b0, exp_rv});
    if (exp_rv) chk({"R10 rdata in request cycle ", tag}, rdata, exp_rd);
    exp_rv = 1'b0;
    for (int k = 1; k <= n; k++) begin
      step();
      @(negedge clk);
      chk({"R4 access addr ", tag}, mem_addr, a);
      chk({"R3 pause shape ", tag}, {31'b0, pause}, {31'b0, (k != n)});
      chk({"R5 strobe shape ", tag}, {31'b0, mem_we},
          {31'b0, (w && !(a[31] && (k == 1 || k == n)))});
      chk({"R6 byte enables ", tag}, {28'b0, mem_be}, {28'b0, exp_be(a, sz)});
      chk({"R7 wdrive ", tag}, {31'b0, mem_wdrive}, {31'b0, w});
      chk({"R7 wdata lanes ", tag}, mem_wdata, w ? exp_wd(d, sz) : 32'd0);
      chk({"R8 no early valid ", tag}, {31'b0, rdata_valid}, 32'd0);
    end
    step();
    if (!keep) req_valid = 1'b0;
    pc = pc + 32'd4;
    if (!w) begin exp_rv = 1'b1; exp_rd = rd; end
    mem_rdata = 32'hDEAD_BEEF;
  endtask

  task automatic t_reset();
    rst = 1'b1; pc = 32'h0000_002C; req_valid = 1'b0; req_write = 1'b0;
    req_size = 2'd0; req_addr = '0; req_wdata = '0; mem_rdata = '0;
    repeat (3) step();
    rst = 1'b0;
    idle_check("R1 after reset");
    pc = 32'h0000_0040;
    idle_check("R2 pc follows");
  endtask

  task automatic t_store_lo_byte();
    pc = 32'h0000_0030;
    access(32'h0000_FFFF, 1'b1, 2'd0, 32'h0000_006A, 32'h0, 1'b0, "lo byte off3");
    idle_check("after lo byte");
  endtask

  task automatic t_store_hi_byte();
    access(32'h8000_0102, 1'b1, 2'd0, 32'h1234_56A5, 32'h0, 1'b0, "hi byte off2");
    idle_check("after hi byte");
    access(32'h8000_0100, 1'b1, 2'd0, 32'h0000_0031, 32'h0, 1'b0, "hi byte off0");
    idle_check("after hi byte off0");
  endtask

  task automatic t_store_half();
    access(32'h0000_0010, 1'b1, 2'd1, 32'hFFFF_BEEF, 32'h0, 1'b0, "lo half upper");
    idle_check("after lo half");
    access(32'h8000_0012, 1'b1, 2'd1, 32'h0000_C0DE, 32'h0, 1'b0, "hi half lower");
    idle_check("after hi half");
  endtask

  task automatic t_store_word();
    access(32'h8000_0200, 1'b1, 2'd2, 32'hCAFE_F00D, 32'h0, 1'b0, "hi word");
    idle_check("after hi word");
    access(32'h0000_0204, 1'b1, 2'd3, 32'h0102_0304, 32'h0, 1'b0, "lo word size3");
    idle_check("after lo word");
  endtask

  task automatic t_loads();
    access(32'h0000_0300, 1'b0, 2'd2, 32'h0, 32'h1122_3344, 1'b0, "lo load");
    idle_check("after lo load");
    access(32'h8000_0301, 1'b0, 2'd0, 32'h0, 32'h5566_7788, 1'b0, "hi load");
    idle_check("after hi load");
  endtask

  task automatic t_back_to_back();
    access(32'h0000_0400, 1'b0, 2'd2, 32'h0, 32'hA5A5_0F0F, 1'b1, "b2b load");
    access(32'h8000_0403, 1'b1, 2'd0, 32'h0000_00E7, 32'h0, 1'b0, "R10 b2b store");
    idle_check("after b2b");
  endtask

  task automatic t_reset_mid_access();
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2;
    req_addr = 32'h8000_0500; req_wdata = 32'h7777_7777;
    step(); req_valid = 1'b0;
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    idle_check("R1 reset mid access");
  endtask

  initial begin
    t_reset();
    t_store_lo_byte();
    t_store_hi_byte();
    t_store_half();
    t_store_word();
    t_loads();
    t_back_to_back();
    t_reset_mid_access();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule